// File: doc/BRIEF.md
# Calendar Alarm Match Comparator

This block watches the running calendar time and compares it with one programmed alarm setting. All time fields arrive in BCD: seconds, minutes, hours (with a 12/24-hour format bit and an AM/PM bit), day of week, day of month and month. A three-bit match selector chooses which fields must agree. When the selected condition holds on a clock cycle where the calendar has just advanced, the block sets a sticky alarm flag.

The flag stays set until software clears it. The interrupt output is the flag gated by an alarm enable. The enable changes only the output, never the flag. The calendar counter, the register bus and any conversion between 12-hour and 24-hour hours are outside this block. The alarm side has no format bit of its own: it always follows the format bit of the timekeeping hours.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset (`rst_n` low), `alm_flag` and `alm_irq` are 0.
- R2: With `alm_mode` = 3'b000, a `tick` cycle where the 7-bit BCD seconds fields are equal sets `alm_flag` at the next rising edge. Unequal seconds leave it clear.
- R3: With `alm_mode` = 3'b001, a `tick` cycle where the 7-bit BCD minutes fields are equal sets `alm_flag`.
- R4: With `alm_mode` = 3'b010, the hours are compared. When `cur_fmt12` = 0 (24-hour format), all 6 hour bits are compared and the PM bits are ignored. When `cur_fmt12` = 1 (12-hour format), hour bits [4:0] are compared and `cur_pm` must equal `alm_pm`.
- R5: With `alm_mode` = 3'b011, the flag is set on a `tick` only when the day-of-week fields are equal and the time is midnight. Midnight means seconds 0x00, minutes 0x00, and either hours 0x00 in 24-hour format or hours 0x12 with `cur_pm` = 0 in 12-hour format.
- R6: With `alm_mode` = 3'b100, a `tick` cycle where the 6-bit BCD day-of-month fields are equal sets `alm_flag`.
- R7: `alm_mode` values 3'b101 and 3'b110 never set `alm_flag`, even when every field matches.
- R8: With `alm_mode` = 3'b111, the flag is set only when seconds, minutes, hours (under the R4 rule), day of week, day of month and month all match at once.
- R9: `alm_flag` holds its value until `flag_clr` is pulsed; the clear takes effect at the next edge. When a qualifying match and `flag_clr` occur in the same cycle, the flag is set.
- R10: `alm_irq` equals `alm_flag` AND `alm_en`. The value of `alm_en` never changes `alm_flag`.
- R11: Matches are evaluated only in cycles with `tick` = 1. Matching fields without `tick` do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe: calendar time just advanced |
| flag_clr | input | 1 | One-cycle software clear of the alarm flag |
| alm_en | input | 1 | Alarm interrupt enable |
| alm_mode | input | 3 | Match selector |
| cur_fmt12 | input | 1 | Hours format: 1 = 12-hour, 0 = 24-hour |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hr | input | 6 | Current hours, BCD |
| cur_pm | input | 1 | Current PM indication (12-hour format) |
| cur_wday | input | 3 | Current day of week |
| cur_date | input | 6 | Current day of month, BCD |
| cur_month | input | 5 | Current month, BCD |
| alm_sec | input | 7 | Alarm seconds, BCD |
| alm_min | input | 7 | Alarm minutes, BCD |
| alm_hr | input | 6 | Alarm hours, BCD |
| alm_pm | input | 1 | Alarm PM indication |
| alm_wday | input | 3 | Alarm day of week |
| alm_date | input | 6 | Alarm day of month, BCD |
| alm_month | input | 5 | Alarm month, BCD |
| alm_flag | output | 1 | Sticky alarm flag |
| alm_irq | output | 1 | Alarm interrupt (flag gated by enable) |

## Verification
The hardest case to reach is the day-of-week midnight mode. The day must match and the whole time of day must be zero, and midnight is encoded differently in the two hour formats. The stimulus loads the calendar inputs directly instead of waiting for a counter to roll over. It applies a true midnight in 24-hour format, then 12:00:00 AM in 12-hour format. It also applies the near misses: one second past midnight, the wrong weekday, and 12:00:00 PM. The same direct loading puts the reserved modes in front of fully matching fields, so a decode error in those modes would show up as a set flag.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared field widths and the match selector encoding for the
// calendar alarm comparator. Assumes BCD time fields throughout.
package rtc_alarm_pkg;
    localparam int SEC_W   = 7;
    localparam int MIN_W   = 7;
    localparam int HR_W    = 6;
    localparam int WDAY_W  = 3;
    localparam int DATE_W  = 6;
    localparam int MON_W   = 5;
    localparam int MODE_W  = 3;

    // Twelve o'clock in BCD, used as the 12-hour midnight hour value
    localparam logic [7:0] BCD_TWELVE = 8'h12;

    typedef enum logic [MODE_W-1:0] {
        MM_SEC   = 3'b000,
        MM_MIN   = 3'b001,
        MM_HOUR  = 3'b010,
        MM_WDAY  = 3'b011,
        MM_DATE  = 3'b100,
        MM_RSV5  = 3'b101,
        MM_RSV6  = 3'b110,
        MM_ALL   = 3'b111
    } match_mode_e;
endpackage

// File: rtl/rtc_field_eq.sv
// Module: equality compare of one BCD calendar field against its alarm value.
// Assumes both operands share the same width and encoding.
module rtc_field_eq #(
    parameter int W = 7
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] alm_val,
    output logic         eq
);
    // Purpose: flag exact agreement of the two values
    always_comb begin
        eq = (cur_val == alm_val);
    end
endmodule

// File: rtl/rtc_hour_cmp.sv
// Module: format-aware hours comparison plus midnight detection.
// Assumes the alarm hours share the timekeeping format bit (fmt12);
// in 12-hour mode the top hour bit is unused and PM takes part.
module rtc_hour_cmp #(
    parameter int HR_W = 6
) (
    input  logic            fmt12,
    input  logic [HR_W-1:0] cur_hr,
    input  logic            cur_pm,
    input  logic [HR_W-1:0] alm_hr,
    input  logic            alm_pm,
    output logic            hr_eq,
    output logic            hr_midnight
);
    import rtc_alarm_pkg::*;

    localparam int H12_W = HR_W - 1;
    localparam logic [HR_W-1:0] TWELVE = BCD_TWELVE[HR_W-1:0];

    logic low_eq;
    logic full_eq;

    // Purpose: compare the shared low hour bits and the full hour value
    always_comb begin
        low_eq  = (cur_hr[H12_W-1:0] == alm_hr[H12_W-1:0]);
        full_eq = (cur_hr == alm_hr);
    end

    // Purpose: choose the comparison rule from the hours format
    always_comb begin
        if (fmt12) begin
            hr_eq       = low_eq && (cur_pm == alm_pm);
            hr_midnight = (cur_hr[H12_W-1:0] == TWELVE[H12_W-1:0]) && !cur_pm;
        end else begin
            hr_eq       = full_eq;
            hr_midnight = (cur_hr == '0);
        end
    end
endmodule

// File: rtl/rtc_match_sel.sv
// Module: decodes the match selector into a single hit signal from the
// per-field equality results. Assumes reserved selector codes never hit.
module rtc_match_sel #(
    parameter int SEC_W  = 7,
    parameter int MIN_W  = 7,
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic              sec_eq,
    input  logic              min_eq,
    input  logic              hr_eq,
    input  logic              hr_midnight,
    input  logic              wday_eq,
    input  logic              date_eq,
    input  logic              mon_eq,
    output logic              hit
);
    import rtc_alarm_pkg::*;

    logic at_midnight;

    // Purpose: whole time of day at zero (format handled upstream)
    always_comb begin
        at_midnight = (cur_sec == '0) && (cur_min == '0) && hr_midnight;
    end

    // Purpose: pick the match condition named by the selector
    always_comb begin
        unique case (match_mode_e'(mode))
            MM_SEC:  hit = sec_eq;
            MM_MIN:  hit = min_eq;
            MM_HOUR: hit = hr_eq;
            MM_WDAY: hit = wday_eq && at_midnight;
            MM_DATE: hit = date_eq;
            MM_ALL:  hit = sec_eq && min_eq && hr_eq && wday_eq && date_eq && mon_eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_flag.sv
// Module: sticky alarm flag. Sets on a strobed hit, clears on request;
// a set in the same cycle as a clear wins so no event is lost.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    // Purpose: hold the flag, set by qualifying strobes, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (tick && hit)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Module: top of the calendar alarm comparator. Compares the programmed
// alarm fields with the running time on each time-updated strobe and
// raises a sticky flag; the interrupt is the flag gated by the enable.
// Assumes all time fields are BCD and stable while tick is high.
module rtc_alarm_cmp #(
    parameter int SEC_W  = rtc_alarm_pkg::SEC_W,
    parameter int MIN_W  = rtc_alarm_pkg::MIN_W,
    parameter int HR_W   = rtc_alarm_pkg::HR_W,
    parameter int WDAY_W = rtc_alarm_pkg::WDAY_W,
    parameter int DATE_W = rtc_alarm_pkg::DATE_W,
    parameter int MON_W  = rtc_alarm_pkg::MON_W,
    parameter int MODE_W = rtc_alarm_pkg::MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              flag_clr,
    input  logic              alm_en,
    input  logic [MODE_W-1:0] alm_mode,
    input  logic              cur_fmt12,
    input  logic [SEC_W-1:0]  cur_sec,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HR_W-1:0]   cur_hr,
    input  logic              cur_pm,
    input  logic [WDAY_W-1:0] cur_wday,
    input  logic [DATE_W-1:0] cur_date,
    input  logic [MON_W-1:0]  cur_month,
    input  logic [SEC_W-1:0]  alm_sec,
    input  logic [MIN_W-1:0]  alm_min,
    input  logic [HR_W-1:0]   alm_hr,
    input  logic              alm_pm,
    input  logic [WDAY_W-1:0] alm_wday,
    input  logic [DATE_W-1:0] alm_date,
    input  logic [MON_W-1:0]  alm_month,
    output logic              alm_flag,
    output logic              alm_irq
);
    logic sec_eq, min_eq, wday_eq, date_eq, mon_eq;
    logic hr_eq, hr_midnight;
    logic hit;

    rtc_field_eq #(.W(SEC_W)) u_sec_eq (
        .cur_val(cur_sec), .alm_val(alm_sec), .eq(sec_eq));
    rtc_field_eq #(.W(MIN_W)) u_min_eq (
        .cur_val(cur_min), .alm_val(alm_min), .eq(min_eq));
    rtc_field_eq #(.W(WDAY_W)) u_wday_eq (
        .cur_val(cur_wday), .alm_val(alm_wday), .eq(wday_eq));
    rtc_field_eq #(.W(DATE_W)) u_date_eq (
        .cur_val(cur_date), .alm_val(alm_date), .eq(date_eq));
    rtc_field_eq #(.W(MON_W)) u_mon_eq (
        .cur_val(cur_month), .alm_val(alm_month), .eq(mon_eq));

    rtc_hour_cmp #(.HR_W(HR_W)) u_hour (
        .fmt12       (cur_fmt12),
        .cur_hr      (cur_hr),
        .cur_pm      (cur_pm),
        .alm_hr      (alm_hr),
        .alm_pm      (alm_pm),
        .hr_eq       (hr_eq),
        .hr_midnight (hr_midnight)
    );

    rtc_match_sel #(.SEC_W(SEC_W), .MIN_W(MIN_W), .MODE_W(MODE_W)) u_sel (
        .mode        (alm_mode),
        .cur_sec     (cur_sec),
        .cur_min     (cur_min),
        .sec_eq      (sec_eq),
        .min_eq      (min_eq),
        .hr_eq       (hr_eq),
        .hr_midnight (hr_midnight),
        .wday_eq     (wday_eq),
        .date_eq     (date_eq),
        .mon_eq      (mon_eq),
        .hit         (hit)
    );

    rtc_alarm_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hit   (hit),
        .clr   (flag_clr),
        .flag  (alm_flag)
    );

    // Purpose: gate the sticky flag onto the interrupt output
    always_comb begin
        alm_irq = alm_flag && alm_en;
    end
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
// Checker: temporal properties of the alarm comparator at its ports.
module rtc_alarm_cmp_chk #(
    parameter int SEC_W  = 7,
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              flag_clr,
    input logic              alm_en,
    input logic [MODE_W-1:0] alm_mode,
    input logic [SEC_W-1:0]  cur_sec,
    input logic [SEC_W-1:0]  alm_sec,
    input logic              alm_flag,
    input logic              alm_irq
);
    // R1: flag is clear in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !alm_flag);

    // R2: a seconds match on a strobe sets the flag
    p_sec_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && alm_mode == 3'b000 && cur_sec == alm_sec) |=> alm_flag);

    // R7: reserved selectors never raise a clear flag
    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (alm_mode == 3'b101 || alm_mode == 3'b110) && !alm_flag) |=> !alm_flag);

    // R9: flag is sticky without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_flag && !flag_clr) |=> alm_flag);

    // R9: a clear without a strobe drops the flag
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !tick) |=> !alm_flag);

    // R10: interrupt never without the flag and the enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alm_irq |-> (alm_flag && alm_en));

    // R11: no strobe, no new flag
    p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !alm_flag) |=> !alm_flag);
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk #(.SEC_W(SEC_W), .MODE_W(MODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .flag_clr (flag_clr),
    .alm_en   (alm_en),
    .alm_mode (alm_mode),
    .cur_sec  (cur_sec),
    .alm_sec  (alm_sec),
    .alm_flag (alm_flag),
    .alm_irq  (alm_irq)
);

// File: tb/rtc_alarm_cmp_bench.sv
// Bench: scoreboard style. The driver task applies one cycle of stimulus and
// queues the expected outputs; the monitor pops and compares after each edge.
module rtc_alarm_cmp_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic       alm_en = 1'b1;
    logic [2:0] alm_mode = 3'b000;
    logic       cur_fmt12 = 1'b0;
    logic [6:0] cur_sec = '0, alm_sec = '0;
    logic [6:0] cur_min = '0, alm_min = '0;
    logic [5:0] cur_hr = '0, alm_hr = '0;
    logic       cur_pm = 1'b0, alm_pm = 1'b0;
    logic [2:0] cur_wday = '0, alm_wday = '0;
    logic [5:0] cur_date = '0, alm_date = '0;
    logic [4:0] cur_month = '0, alm_month = '0;
    logic       alm_flag, alm_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    rtc_alarm_cmp u_rtc_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .flag_clr(flag_clr),
        .alm_en(alm_en), .alm_mode(alm_mode), .cur_fmt12(cur_fmt12),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hr(cur_hr), .cur_pm(cur_pm),
        .cur_wday(cur_wday), .cur_date(cur_date), .cur_month(cur_month),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr), .alm_pm(alm_pm),
        .alm_wday(alm_wday), .alm_date(alm_date), .alm_month(alm_month),
        .alm_flag(alm_flag), .alm_irq(alm_irq)
    );

    // Monitor: compare outputs just after each edge with the queued item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (alm_flag !== e.flag || alm_irq !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: flag/irq actual %b/%b expected %b/%b",
                             e.tag, alm_flag, alm_irq, e.flag, e.irq);
                end
            end
        end
    end

    // Driver: one cycle of strobe/clear, expected result queued for the monitor
    task automatic step(input logic t, input logic c, input logic ef, input string tag);
        exp_t e;
        @(negedge clk);
        tick = t;
        flag_clr = c;
        e.flag = ef;
        e.irq = ef & alm_en;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #2;
        tick = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic set_cur(input logic f12, input logic [5:0] h, input logic pm,
                           input logic [6:0] m, input logic [6:0] s,
                           input logic [2:0] wd, input logic [5:0] d, input logic [4:0] mo);
        cur_fmt12 = f12; cur_hr = h; cur_pm = pm; cur_min = m; cur_sec = s;
        cur_wday = wd; cur_date = d; cur_month = mo;
    endtask

    task automatic set_alm(input logic [5:0] h, input logic pm,
                           input logic [6:0] m, input logic [6:0] s,
                           input logic [2:0] wd, input logic [5:0] d, input logic [4:0] mo);
        alm_hr = h; alm_pm = pm; alm_min = m; alm_sec = s;
        alm_wday = wd; alm_date = d; alm_month = mo;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step(0, 0, 0, "R1 reset state");

        // 24-hour 13:45:30, weekday 3, date 15, month 06
        set_cur(0, 6'h13, 0, 7'h45, 7'h30, 3'd3, 6'h15, 5'h06);
        set_alm(6'h09, 0, 7'h00, 7'h30, 3'd1, 6'h01, 5'h01);
        alm_mode = 3'b000;
        step(0, 0, 0, "R11 seconds match without tick");
        step(1, 0, 1, "R2 seconds match");
        step(0, 1, 0, "R9 clear");
        alm_sec = 7'h31;
        step(1, 0, 0, "R2 seconds mismatch");

        alm_mode = 3'b001; alm_min = 7'h45;
        step(1, 0, 1, "R3 minutes match");
        step(0, 1, 0, "R9 clear");
        alm_min = 7'h44;
        step(1, 0, 0, "R3 minutes mismatch");

        alm_mode = 3'b010; alm_hr = 6'h13; alm_pm = 1'b1;
        step(1, 0, 1, "R4 24h hours match, pm ignored");
        step(0, 1, 0, "R9 clear");
        set_cur(1, 6'h01, 1, 7'h45, 7'h30, 3'd3, 6'h15, 5'h06);
        alm_hr = 6'h01; alm_pm = 1'b0;
        step(1, 0, 0, "R4 12h hours pm differs");
        alm_pm = 1'b1;
        step(1, 0, 1, "R4 12h hours and pm match");
        step(0, 1, 0, "R9 clear");

        alm_mode = 3'b011; set_alm(6'h05, 0, 7'h12, 7'h34, 3'd3, 6'h01, 5'h01);
        set_cur(0, 6'h00, 0, 7'h00, 7'h00, 3'd3, 6'h15, 5'h06);
        step(1, 0, 1, "R5 24h midnight on weekday");
        step(0, 1, 0, "R9 clear");
        cur_sec = 7'h01;
        step(1, 0, 0, "R5 one second past midnight");
        cur_sec = 7'h00; cur_wday = 3'd4;
        step(1, 0, 0, "R5 midnight wrong weekday");
        set_cur(1, 6'h12, 0, 7'h00, 7'h00, 3'd3, 6'h15, 5'h06);
        step(1, 0, 1, "R5 12h 12:00:00 AM");
        step(0, 1, 0, "R9 clear");
        cur_pm = 1'b1;
        step(1, 0, 0, "R5 12h 12:00:00 PM");

        alm_mode = 3'b100; alm_date = 6'h15;
        step(1, 0, 1, "R6 date match");
        step(0, 1, 0, "R9 clear");
        alm_date = 6'h16;
        step(1, 0, 0, "R6 date mismatch");

        // All fields equal: 24h 08:20:10, weekday 2, date 28, month 11
        set_cur(0, 6'h08, 0, 7'h20, 7'h10, 3'd2, 6'h28, 5'h11);
        set_alm(6'h08, 0, 7'h20, 7'h10, 3'd2, 6'h28, 5'h11);
        alm_mode = 3'b101;
        step(1, 0, 0, "R7 reserved 101");
        alm_mode = 3'b110;
        step(1, 0, 0, "R7 reserved 110");
        alm_mode = 3'b111; alm_month = 5'h12;
        step(1, 0, 0, "R8 all but month");
        alm_month = 5'h11;
        step(1, 0, 1, "R8 all fields match");

        step(0, 0, 1, "R9 flag holds");
        step(1, 1, 1, "R9 set wins over clear");
        alm_en = 1'b0;
        step(0, 0, 1, "R10 enable low masks irq, flag kept");
        alm_en = 1'b1;
        step(0, 0, 1, "R10 enable high drives irq");
        step(0, 1, 0, "R9 final clear");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule